// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between the transmit data pin of a CAN transceiver and the enable of its bus driver. A low transmit input asks for a dominant bus level and a high input leaves the bus recessive. The guard passes that request through unless one of three things stops it: the mode controller has withdrawn its transmit permit, the transmit input has been held low for longer than a timeout, or the over-temperature flag has tripped.

Both fault causes latch. A timeout fault clears only when the transmit input is seen high at a clock edge. A thermal fault clears only when the synchronized temperature flag is low and the transmit input is high at the same edge. This means a node whose transmit line is stuck low cannot start driving dominant again after the fault condition goes away. Only the driver is gated. The timer and the thermal latch keep running whatever the permit is.

The timeout is set in clock cycles. It is raised to a floor of one millisecond, so the slowest legal bit rate, about 17 kbit/s, is never cut short. The over-temperature input passes through a synchronizer of configurable depth.

Top module: `txd_guard_top`

## Requirements
- R1: `drv_dom_o` is high in the same cycle exactly when `txd_i` is low, `tx_permit_i` is high and both fault bits are clear. This is purely combinational from the current inputs and the latched faults.
- R2: During and after reset both fault bits are 0. The timer is empty, and `txd_i` is treated as having been high before reset.
- R3: Count the consecutive clock edges at which `txd_i` is sampled low. The timeout fault `fault_o[0]` is set at the edge where this count reaches the effective limit. Before that edge the driver stays dominant, and after it the driver is recessive.
- R4: Any clock edge that samples `txd_i` high clears the timeout fault and empties the timer. A high pulse that falls between two edges is not seen and clears nothing. The next low level drives dominant at once, with a fresh full window.
- R5: `ot_i` passes through `OT_SYNC` flip-flops and sets the thermal fault `fault_o[1]` at the next edge, so there are OT_SYNC+1 edges of latency. Setting takes priority over clearing. The fault clears only at an edge where the synchronized flag is low and `txd_i` is high, and it stays set while `txd_i` is low.
- R6: The timeout timer runs whatever the state of `tx_permit_i` and of the thermal fault.
- R7: The effective limit is the larger of `TIMEOUT_CYC` and `CLK_KHZ`. `CLK_KHZ` is the number of cycles in one millisecond.
- R8: `fault_o` bit 0 is the timeout cause and bit 1 is the thermal cause. The two are independent and may both be set, or rise at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txd_i | input | 1 | Transmit data, low requests dominant |
| ot_i | input | 1 | Over-temperature flag, asynchronous |
| tx_permit_i | input | 1 | Transmit permit from the mode controller |
| drv_dom_o | output | 1 | Command the bus driver dominant |
| fault_o | output | 2 | Latched causes: bit 0 timeout, bit 1 thermal |

## Verification
The timeout and the thermal trip can land on the same clock edge. The bench provokes this by holding the transmit input low and timing the rise of the over-temperature flag so that its synchronized copy reaches the latch at the very edge where the low run reaches the limit. It then checks that the status word is 00 one cycle before that edge and 11 just after it, that the driver drops in step, and that a single high sample after the flag has fallen clears both causes together.

// File: rtl/txg_pkg.sv
package txg_pkg;

  typedef struct packed {
    logic thermal;
    logic timeout;
  } txg_fault_t;

  function automatic int unsigned eff_limit(int unsigned tmo_cyc, int unsigned khz);
    return (tmo_cyc < khz) ? khz : tmo_cyc;
  endfunction

endpackage

// File: rtl/txg_txd_edge.sv
module txg_txd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_i,
  output logic txd_low_o,
  output logic fall_o
);
  logic txd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txd_q <= 1'b1;
    else        txd_q <= txd_i;
  end

  assign txd_low_o = ~txd_i;
  assign fall_o    = txd_q & ~txd_i;
endmodule

// File: rtl/txg_dom_timer.sv
module txg_dom_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_low_i,
  input  logic fall_i,
  output logic tmo_flt_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc = cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      tmo_flt_o <= 1'b0;
    end else if (!txd_low_i) begin
      cnt       <= '0;
      tmo_flt_o <= 1'b0;
    end else if (fall_i) begin
      cnt       <= CW'(1);
      tmo_flt_o <= (LIMIT == 1);
    end else if (cnt != LIM_V) begin
      cnt       <= cnt_inc;
      tmo_flt_o <= (cnt_inc == LIM_V);
    end
  end
endmodule

// File: rtl/txg_ot_sync.sv
module txg_ot_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ot_i,
  output logic ot_s_o
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], ot_i};
  end

  assign ot_s_o = sh[STAGES-1];
endmodule

// File: rtl/txg_therm_latch.sv
module txg_therm_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ot_s_i,
  input  logic txd_high_i,
  output logic thm_flt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     thm_flt_o <= 1'b0;
    else if (ot_s_i)                thm_flt_o <= 1'b1;
    else if (txd_high_i)            thm_flt_o <= 1'b0;
  end
endmodule

// File: rtl/txd_guard_top.sv
module txd_guard_top #(
  parameter int unsigned TIMEOUT_CYC = 80000,
  parameter int unsigned CLK_KHZ     = 40000,
  parameter int unsigned OT_SYNC     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txd_i,
  input  logic       ot_i,
  input  logic       tx_permit_i,
  output logic       drv_dom_o,
  output logic [1:0] fault_o
);
  import txg_pkg::*;

  localparam int unsigned LIM = eff_limit(TIMEOUT_CYC, CLK_KHZ);

  logic       txd_low;
  logic       fall;
  logic       ot_s;
  txg_fault_t flt;

  txg_txd_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .txd_i    (txd_i),
    .txd_low_o(txd_low),
    .fall_o   (fall)
  );

  txg_dom_timer #(.LIMIT(LIM)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .txd_low_i(txd_low),
    .fall_i   (fall),
    .tmo_flt_o(flt.timeout)
  );

  generate
    if (OT_SYNC == 0) begin : g_ot_direct
      assign ot_s = ot_i;
    end else if (OT_SYNC == 1) begin : g_ot_one
      logic ot_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ot_q <= 1'b0;
        else        ot_q <= ot_i;
      end
      assign ot_s = ot_q;
    end else begin : g_ot_chain
      txg_ot_sync #(.STAGES(OT_SYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .ot_i  (ot_i),
        .ot_s_o(ot_s)
      );
    end
  endgenerate

  txg_therm_latch u_therm (
    .clk       (clk),
    .rst_n     (rst_n),
    .ot_s_i    (ot_s),
    .txd_high_i(~txd_low),
    .thm_flt_o (flt.thermal)
  );

  assign drv_dom_o = txd_low & tx_permit_i & ~flt.timeout & ~flt.thermal;
  assign fault_o   = flt;
endmodule

// File: rtl/txg_guard_chk.sv
module txg_guard_chk #(
  parameter int unsigned TIMEOUT_CYC = 80000,
  parameter int unsigned CLK_KHZ     = 40000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       txd_i,
  input logic       tx_permit_i,
  input logic       drv_dom_o,
  input logic [1:0] fault_o
);
  localparam int unsigned LIM = txg_pkg::eff_limit(TIMEOUT_CYC, CLK_KHZ);
  localparam int unsigned CW  = $clog2(LIM + 1);

  logic [CW-1:0] lowrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  lowrun <= '0;
    else if (txd_i)              lowrun <= '0;
    else if (lowrun != CW'(LIM)) lowrun <= lowrun + 1'b1;
  end

  p_dom_needs_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    drv_dom_o |-> (!txd_i && tx_permit_i));

  p_fault_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o != 2'b00) |-> !drv_dom_o);

  p_tmo_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lowrun < CW'(LIM)) |-> !fault_o[0]);

  p_tmo_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lowrun == CW'(LIM)) |-> fault_o[0]);

  p_tmo_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    txd_i |=> !fault_o[0]);

  p_thm_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o[1] && !txd_i) |=> fault_o[1]);
endmodule

bind txd_guard_top txg_guard_chk #(.TIMEOUT_CYC(TIMEOUT_CYC), .CLK_KHZ(CLK_KHZ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .txd_i      (txd_i),
  .tx_permit_i(tx_permit_i),
  .drv_dom_o  (drv_dom_o),
  .fault_o    (fault_o)
);

// File: tb/test_txd_guard_top.sv
module test_txd_guard_top;
  localparam int CLK_PERIOD = 10;
  localparam int LIM  = 12;   // main: TIMEOUT_CYC 12, CLK_KHZ 4
  localparam int LIM2 = 5;    // clamp: TIMEOUT_CYC 3, CLK_KHZ 5
  localparam int SYN  = 2;

  logic clk = 1'b0, rst_n = 1'b0, txd = 1'b1, ot = 1'b0, permit = 1'b1;
  logic ot_off = 1'b0;
  logic drv, drv2;
  logic [1:0] flt, flt2;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txd_guard_top #(.TIMEOUT_CYC(12), .CLK_KHZ(4), .OT_SYNC(SYN)) i_txd_guard_top (
    .clk(clk), .rst_n(rst_n), .txd_i(txd), .ot_i(ot), .tx_permit_i(permit),
    .drv_dom_o(drv), .fault_o(flt));

  txd_guard_top #(.TIMEOUT_CYC(3), .CLK_KHZ(5), .OT_SYNC(0)) i_txd_guard_top_clamp (
    .clk(clk), .rst_n(rst_n), .txd_i(txd), .ot_i(ot_off), .tx_permit_i(permit),
    .drv_dom_o(drv2), .fault_o(flt2));

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    // R2: reset state
    repeat (3) nxt();
    #1;
    chk("R2 fault in reset", flt, 2'b00);
    chk("R2 drv in reset", {1'b0, drv}, 2'b00);
    rst_n = 1'b1;
    nxt(); #1;
    chk("R2 fault after reset", flt, 2'b00);

    // R3 R4 R7: sweep of low widths, both instances
    for (int w = 1; w <= LIM + 3; w++) begin
      nxt(); txd = 1'b0;
      for (int n = 0; n < w; n++) begin
        #1;
        chk("R3 drv main", {1'b0, drv}, {1'b0, n < LIM});
        chk("R3 timeout bit main", {1'b0, flt[0]}, {1'b0, n >= LIM});
        chk("R7 drv clamp", {1'b0, drv2}, {1'b0, n < LIM2});
        nxt();
      end
      txd = 1'b1; #1;
      chk("R4 latched before high edge", {1'b0, flt[0]}, {1'b0, w >= LIM});
      chk("R1 drv high txd", {1'b0, drv}, 2'b00);
      nxt(); #1;
      chk("R4 cleared by high edge", flt, 2'b00);
      chk("R4 clamp cleared", flt2, 2'b00);
    end

    // R4: high pulse between edges clears nothing; one high edge rearms
    nxt(); txd = 1'b0;
    repeat (LIM + 1) nxt();
    #1; txd = 1'b1; #2; txd = 1'b0;
    nxt(); #1;
    chk("R4 glitch ignored fault", flt, 2'b01);
    chk("R4 glitch ignored drv", {1'b0, drv}, 2'b00);
    txd = 1'b1; nxt(); txd = 1'b0; #1;
    chk("R4 rearmed drv", {1'b0, drv}, 2'b01);
    nxt(); txd = 1'b1; nxt();

    // R1: permit and level combinations from clean state
    for (int c = 0; c < 4; c++) begin
      txd = c[0]; permit = c[1]; #1;
      chk("R1 combo", {1'b0, drv}, {1'b0, !c[0] && c[1]});
      txd = 1'b1; permit = 1'b1; nxt(); nxt();
    end

    // R6: timer runs with permit low
    permit = 1'b0; txd = 1'b0;
    repeat (LIM) nxt();
    #1;
    chk("R6 timeout with permit low", flt, 2'b01);
    permit = 1'b1; #1;
    chk("R6 drv held recessive", {1'b0, drv}, 2'b00);
    txd = 1'b1; nxt(); nxt(); #1;
    chk("R6 cleared", flt, 2'b00);

    // R5: thermal latency, priority over clear, hold while low
    ot = 1'b1;
    for (int n = 1; n <= SYN + 1; n++) begin
      nxt(); #1;
      chk("R5 thermal latency", {1'b0, flt[1]}, {1'b0, n == SYN + 1});
    end
    nxt(); nxt(); #1;
    chk("R5 set wins with txd high", flt, 2'b10);
    txd = 1'b0; #1;
    chk("R5 drv blocked", {1'b0, drv}, 2'b00);
    ot = 1'b0;
    repeat (SYN + 3) nxt();
    #1;
    chk("R5 held while txd low", {1'b0, flt[1]}, 2'b01);
    txd = 1'b1; nxt(); #1;
    chk("R5 cleared", flt, 2'b00);
    nxt(); txd = 1'b0; #1;
    chk("R5 dominant again", {1'b0, drv}, 2'b01);
    nxt(); txd = 1'b1; nxt(); nxt();

    // R8: both causes at one edge (edge number LIM after txd falls)
    txd = 1'b0;
    for (int n = 0; n < LIM; n++) begin
      if (n == LIM - SYN - 1) ot = 1'b1;
      nxt();
      if (n == LIM - 2) begin
        #1;
        chk("R8 none before shared edge", flt, 2'b00);
        chk("R8 drv before shared edge", {1'b0, drv}, 2'b01);
      end
    end
    #1;
    chk("R8 both set together", flt, 2'b11);
    chk("R8 drv dropped", {1'b0, drv}, 2'b00);
    ot = 1'b0;
    repeat (SYN + 2) nxt();
    txd = 1'b1; nxt(); #1;
    chk("R8 both cleared", flt, 2'b00);

    report();
  end
endmodule